// File: doc/BRIEF.md
# Conditional Select and Compare Unit

This combinational datapath block carries out the conditional operations of a processor's integer pipeline. A 4-bit condition code is tested against the current flag nibble (negative, zero, carry, overflow). The outcome then steers one of two kinds of operation.

The first kind is a conditional select. When the condition holds, it returns the first operand. When the condition fails, it returns the second operand either unchanged, incremented, inverted or negated.

The second kind is a conditional compare. When the condition holds, it computes fresh flags from a subtraction (or from an addition, for the negative form) of the first operand and a register or small immediate. When the condition fails, it loads the flags from a 4-bit literal instead.

Every operation runs either on 64-bit operands or on their low 32 bits, chosen by a mode input. There is no clock. The surrounding pipeline registers the inputs and the outputs.

Top module: `cond_sel_cmp`

## Requirements
- R1: The flag nibble is ordered N=bit 3, Z=bit 2, C=bit 1, V=bit 0. The condition codes evaluate as follows:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
- R2: Condition codes 14 and 15 are always true, whatever the flags.
- R3: The operation selector `opSel` is decoded as follows:
  - Value 0 is plain select: the result is the first operand when the condition holds and the second operand otherwise.
  - Values 6 and 7 behave exactly like value 0.
- R4: When the condition fails, the other select forms transform the second operand:
  - Value 1 (select-increment) gives the second operand plus one.
  - Value 2 (select-invert) gives its bitwise complement.
  - Value 3 (select-negate) gives its two's-complement negation.
  - When the condition holds, all three return the first operand.
- R5: Value 4 (compare) with a passing condition sets the flags from first minus second:
  - N is the result's top bit.
  - Z is set when the result is all zeros.
  - C is set when no borrow occurs.
  - V is set on signed overflow.
- R6: Value 5 (compare-negative) with a passing condition sets the flags from first plus second:
  - C is the carry out.
  - V is signed overflow.
  - N and Z are as in R5.
- R7: A compare (values 4 and 5) whose condition fails loads `flagsOut` directly from `flagImm`. Every compare drives `result` to zero.
- R8: For a compare with `useImm`=1, the second operand is the 5-bit `immVal`, zero-extended, and `opB` is ignored. For select operations `useImm` has no effect.
- R9: With `wideMode`=0:
  - Only the low 32 bits of the operands are used.
  - The upper 32 result bits are zero.
  - Compare flags come from bit 31 and the carry out of bit 31.
- R10: Select operations (values 0 to 3, 6 and 7) leave the flags unchanged: `flagsOut` equals `flagsIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 3 | Operation selector (R3 to R7) |
| useImm | input | 1 | Compare takes the 5-bit immediate as second operand |
| wideMode | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| opA | input | 64 | First operand |
| opB | input | 64 | Second register operand |
| immVal | input | 5 | Unsigned compare immediate |
| flagImm | input | 4 | Flag literal loaded when a compare's condition fails |
| condCode | input | 4 | Condition code |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| result | output | 64 | Select result, zero for compares |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |

## Verification
The block holds no state, so an internal fault shows at the ports in the very evaluation that triggers it. A control fault appears as a wrong predicate or a wrong strobe:
- A wrong predicate flips a select between its operands.
- A wrong predicate or strobe also swaps computed flags for the literal nibble.
Datapath faults show as a wrong transformed operand, as non-zero upper bits in 32-bit mode, or as a carry or overflow flag taken from the wrong bit position. The bench therefore sweeps every condition code against every flag pattern. It also targets the borrow, carry and overflow edges in both widths.

// File: rtl/cond_sel_cmp_pkg.sv
package cond_sel_cmp_pkg;

  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int COND_W = 4;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SEL  = 3'd0,
    OP_SINC = 3'd1,
    OP_SINV = 3'd2,
    OP_SNEG = 3'd3,
    OP_CMP  = 3'd4,
    OP_CMN  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } opKind_e;

  typedef enum logic [1:0] {
    FM_KEEP = 2'd0,
    FM_INC  = 2'd1,
    FM_INV  = 2'd2,
    FM_NEG  = 2'd3
  } falseMod_e;

  typedef struct packed {
    logic      condPass;
    logic      isCompare;
    logic      doAdd;
    logic      immSrc;
    falseMod_e falseMod;
  } ctrlStrobe_t;

endpackage

// File: rtl/cond_sel_cmp_ctrl.sv
module cond_sel_cmp_ctrl
  import cond_sel_cmp_pkg::*;
(
  input  logic [OP_W-1:0]   opSel,
  input  logic              useImm,
  input  logic [COND_W-1:0] condCode,
  input  logic [FLAG_W-1:0] flagsIn,
  output ctrlStrobe_t       strobe
);

  localparam int PAIR_W = COND_W - 1;

  logic fN, fZ, fC, fV;
  logic basePred;
  logic condPass;
  opKind_e opKind;

  assign fN = flagsIn[FLAG_N];
  assign fZ = flagsIn[FLAG_Z];
  assign fC = flagsIn[FLAG_C];
  assign fV = flagsIn[FLAG_V];

  // Codes come in pairs; the low bit inverts the pair's base predicate.
  always_comb begin
    unique case (condCode[COND_W-1:1])
      PAIR_W'(0): basePred = fZ;
      PAIR_W'(1): basePred = fC;
      PAIR_W'(2): basePred = fN;
      PAIR_W'(3): basePred = fV;
      PAIR_W'(4): basePred = fC & ~fZ;
      PAIR_W'(5): basePred = (fN == fV);
      PAIR_W'(6): basePred = ~fZ & (fN == fV);
      default:    basePred = 1'b1;
    endcase
  end

  assign condPass = (condCode[COND_W-1:1] == {PAIR_W{1'b1}}) ? 1'b1
                                                              : (basePred ^ condCode[0]);

  assign opKind = opKind_e'(opSel);

  always_comb begin
    strobe           = '0;
    strobe.condPass  = condPass;
    strobe.falseMod  = FM_KEEP;
    unique case (opKind)
      OP_SINC: strobe.falseMod = FM_INC;
      OP_SINV: strobe.falseMod = FM_INV;
      OP_SNEG: strobe.falseMod = FM_NEG;
      OP_CMP: begin
        strobe.isCompare = 1'b1;
        strobe.immSrc    = useImm;
      end
      OP_CMN: begin
        strobe.isCompare = 1'b1;
        strobe.doAdd     = 1'b1;
        strobe.immSrc    = useImm;
      end
      default: strobe.falseMod = FM_KEEP;
    endcase
  end

endmodule

// File: rtl/cond_sel_cmp_dpath.sv
module cond_sel_cmp_dpath
  import cond_sel_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  ctrlStrobe_t       strobe,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [FLAG_W-1:0] flagImm,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB_W  = DATA_W - 1;
  localparam int MSB_H  = HALF_W - 1;

  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] aEff, bEff, bMod, selOut, cmpB, addB;
  logic              carryIn;
  logic [DATA_W:0]   wideSum;
  logic [HALF_W:0]   narrowSum;
  logic [FLAG_W-1:0] wideFlags, narrowFlags, calcFlags;

  assign laneMask = wideMode ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign aEff     = opA & laneMask;
  assign bEff     = opB & laneMask;

  // Select path: false-side transform, then clip to the active lane.
  always_comb begin
    unique case (strobe.falseMod)
      FM_INC:  bMod = bEff + {{(DATA_W-1){1'b0}}, 1'b1};
      FM_INV:  bMod = ~bEff;
      FM_NEG:  bMod = ~bEff + {{(DATA_W-1){1'b0}}, 1'b1};
      default: bMod = bEff;
    endcase
  end

  assign selOut = (strobe.condPass ? aEff : bMod) & laneMask;

  // Compare path: one adder serves both forms via inverted operand and carry-in.
  assign cmpB    = strobe.immSrc ? {{(DATA_W-IMM_W){1'b0}}, immVal} : bEff;
  assign addB    = strobe.doAdd ? cmpB : ~cmpB;
  assign carryIn = ~strobe.doAdd;

  assign wideSum   = {1'b0, aEff} + {1'b0, addB} + {{DATA_W{1'b0}}, carryIn};
  assign narrowSum = {1'b0, aEff[MSB_H:0]} + {1'b0, addB[MSB_H:0]}
                   + {{HALF_W{1'b0}}, carryIn};

  always_comb begin
    wideFlags[FLAG_N] = wideSum[MSB_W];
    wideFlags[FLAG_Z] = (wideSum[MSB_W:0] == '0);
    wideFlags[FLAG_C] = wideSum[DATA_W];
    wideFlags[FLAG_V] = (aEff[MSB_W] == addB[MSB_W]) && (wideSum[MSB_W] != aEff[MSB_W]);

    narrowFlags[FLAG_N] = narrowSum[MSB_H];
    narrowFlags[FLAG_Z] = (narrowSum[MSB_H:0] == '0);
    narrowFlags[FLAG_C] = narrowSum[HALF_W];
    narrowFlags[FLAG_V] = (aEff[MSB_H] == addB[MSB_H]) && (narrowSum[MSB_H] != aEff[MSB_H]);
  end

  assign calcFlags = wideMode ? wideFlags : narrowFlags;

  always_comb begin
    if (strobe.isCompare) begin
      result   = '0;
      flagsOut = strobe.condPass ? calcFlags : flagImm;
    end else begin
      result   = selOut;
      flagsOut = flagsIn;
    end
  end

endmodule

// File: rtl/cond_sel_cmp.sv
module cond_sel_cmp
  import cond_sel_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  logic [2:0]        opSel,
  input  logic              useImm,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [3:0]        flagImm,
  input  logic [3:0]        condCode,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsOut
);

  ctrlStrobe_t strobe;
  logic        condPass;

  cond_sel_cmp_ctrl ctrl_i (
    .opSel    (opSel),
    .useImm   (useImm),
    .condCode (condCode),
    .flagsIn  (flagsIn),
    .strobe   (strobe)
  );

  cond_sel_cmp_dpath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) dpath_i (
    .strobe   (strobe),
    .wideMode (wideMode),
    .opA      (opA),
    .opB      (opB),
    .immVal   (immVal),
    .flagImm  (flagImm),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

  assign condPass = strobe.condPass;

endmodule

// File: rtl/cond_sel_cmp_chk.sv
module cond_sel_cmp_chk #(
  parameter int DATA_W = 64
) (
  input logic [2:0]        opSel,
  input logic              wideMode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flagImm,
  input logic [3:0]        condCode,
  input logic [3:0]        flagsIn,
  input logic [3:0]        flagsOut,
  input logic              condPass
);

  localparam int HALF_W = DATA_W / 2;

  logic isCmp;
  logic [DATA_W-1:0] aLane;

  assign isCmp = (opSel == 3'd4) || (opSel == 3'd5);
  assign aLane = wideMode ? opA : {{HALF_W{1'b0}}, opA[HALF_W-1:0]};

  always_comb begin
    a_r2_always_true: assert (!(condCode[3:1] == 3'b111) || condPass)
      else $error("condition 14/15 evaluated false");
    a_r10_flags_kept: assert (isCmp || (flagsOut == flagsIn))
      else $error("select altered flags");
    a_r7_literal_flags: assert (!(isCmp && !condPass) || (flagsOut == flagImm))
      else $error("failed compare did not load literal flags");
    a_r7_cmp_zero_result: assert (!isCmp || (result == '0))
      else $error("compare drove non-zero result");
    a_r9_upper_zero: assert (wideMode || (result[DATA_W-1:HALF_W] == '0))
      else $error("narrow mode upper bits non-zero");
    a_r3_pass_first: assert (isCmp || !condPass || (result == aLane))
      else $error("passing select did not return first operand");
  end

endmodule

bind cond_sel_cmp cond_sel_cmp_chk #(.DATA_W(DATA_W)) chk_i (
  .opSel    (opSel),
  .wideMode (wideMode),
  .opA      (opA),
  .result   (result),
  .flagImm  (flagImm),
  .condCode (condCode),
  .flagsIn  (flagsIn),
  .flagsOut (flagsOut),
  .condPass (condPass)
);

// File: tb/cond_sel_cmp_tb_top.sv
module cond_sel_cmp_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  opSel    = '0;
  logic        useImm   = 1'b0;
  logic        wideMode = 1'b0;
  logic [63:0] opA      = '0;
  logic [63:0] opB      = '0;
  logic [4:0]  immVal   = '0;
  logic [3:0]  flagImm  = '0;
  logic [3:0]  condCode = '0;
  logic [3:0]  flagsIn  = '0;
  logic [63:0] result;
  logic [3:0]  flagsOut;

  cond_sel_cmp dut_i (
    .opSel(opSel), .useImm(useImm), .wideMode(wideMode), .opA(opA), .opB(opB),
    .immVal(immVal), .flagImm(flagImm), .condCode(condCode), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut)
  );

  typedef struct {
    logic [63:0] expRes;
    logic [3:0]  expFlags;
    string       tag;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Independent condition table, flags {N,Z,C,V}
  function automatic logic condRef(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic refModel(input logic [2:0] op, input logic wide, input logic [63:0] a0,
                          input logic [63:0] b0, input logic [4:0] imm, input logic ui,
                          input logic [3:0] fimm, input logic [3:0] cc, input logic [3:0] fin,
                          output logic [63:0] r, output logic [3:0] f);
    logic [63:0] m, a, b, s, res;
    logic pass;
    logic signed [65:0] sa, sb, st;
    logic [64:0] s65;
    m = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    a = a0 & m;
    b = b0 & m;
    pass = condRef(cc, fin);
    if (op == 3'd4 || op == 3'd5) begin
      r = '0;
      s = ui ? {59'd0, imm} : b;
      if (!pass) f = fimm;
      else begin
        sa = wide ? {{2{a[63]}}, a} : {{34{a[31]}}, a[31:0]};
        sb = wide ? {{2{s[63]}}, s} : {{34{s[31]}}, s[31:0]};
        if (op == 3'd4) begin
          res = (a - s) & m;
          f[1] = (a >= s);
          st = sa - sb;
        end else begin
          s65 = {1'b0, a} + {1'b0, s};
          res = s65[63:0] & m;
          f[1] = wide ? s65[64] : s65[32];
          st = sa + sb;
        end
        f[3] = wide ? res[63] : res[31];
        f[2] = (res == 64'd0);
        f[0] = wide ? (st != {{2{st[63]}}, st[63:0]}) : (st != {{34{st[31]}}, st[31:0]});
      end
    end else begin
      f = fin;
      case (op)
        3'd1: s = b + 64'd1;
        3'd2: s = ~b;
        3'd3: s = 64'd0 - b;
        default: s = b;
      endcase
      r = (pass ? a : s) & m;
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic wide, input logic [63:0] a,
                       input logic [63:0] b, input logic [4:0] imm, input logic ui,
                       input logic [3:0] fimm, input logic [3:0] cc, input logic [3:0] fin,
                       input string tag);
    item_t it;
    @(posedge clk);
    opSel = op; wideMode = wide; opA = a; opB = b; immVal = imm; useImm = ui;
    flagImm = fimm; condCode = cc; flagsIn = fin;
    refModel(op, wide, a, b, imm, ui, fimm, cc, fin, it.expRes, it.expFlags);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (result !== it.expRes || flagsOut !== it.expFlags) begin
        errors++;
        $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                 it.tag, result, flagsOut, it.expRes, it.expFlags);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Idle inputs: EQ with Z clear fails, plain select gives B=0 (R3)
    drive(3'd0, 1'b0, 64'd0, 64'd0, 5'd0, 1'b0, 4'd0, 4'd0, 4'd0, "R3 idle");

    // R1 / R2: every code against every flag pattern via plain select
    for (int cc = 0; cc < 16; cc++) begin
      for (int fl = 0; fl < 16; fl++) begin
        drive(3'd0, 1'b1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 5'd0, 1'b0,
              4'd0, 4'(cc), 4'(fl), (cc >= 14) ? "R2" : "R1");
      end
    end

    // R3: reserved selectors act as plain select
    drive(3'd6, 1'b1, 64'hA, 64'hB, 5'd0, 1'b0, 4'd0, 4'd1, 4'b0100, "R3 op6 false");
    drive(3'd7, 1'b1, 64'hA, 64'hB, 5'd0, 1'b0, 4'd0, 4'd0, 4'b0100, "R3 op7 true");

    // R4: false-path transforms, and pass path
    drive(3'd1, 1'b1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 1'b0, 4'd0, 4'd0, 4'b0000, "R4 inc wrap");
    drive(3'd2, 1'b1, 64'h1, 64'h00FF_00FF_00FF_00FF, 5'd0, 1'b0, 4'd0, 4'd0, 4'b0000, "R4 inv");
    drive(3'd3, 1'b1, 64'h1, 64'd5, 5'd0, 1'b0, 4'd0, 4'd0, 4'b0000, "R4 neg");
    drive(3'd3, 1'b1, 64'h77, 64'd5, 5'd0, 1'b0, 4'd0, 4'd0, 4'b0100, "R4 neg pass");
    drive(3'd1, 1'b0, 64'h1, 64'h0000_0000_FFFF_FFFF, 5'd0, 1'b0, 4'd0, 4'd0, 4'b0000, "R4 inc narrow");

    // R5: subtract compare
    drive(3'd4, 1'b1, 64'd5, 64'd5, 5'd0, 1'b0, 4'd0, 4'd14, 4'd0, "R5 equal");
    drive(3'd4, 1'b1, 64'd3, 64'd5, 5'd0, 1'b0, 4'd0, 4'd14, 4'd0, "R5 borrow");
    drive(3'd4, 1'b1, 64'h8000_0000_0000_0000, 64'd1, 5'd0, 1'b0, 4'd0, 4'd14, 4'd0, "R5 overflow");

    // R6: add compare
    drive(3'd5, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 1'b0, 4'd0, 4'd14, 4'd0, "R6 overflow");
    drive(3'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 1'b0, 4'd0, 4'd14, 4'd0, "R6 carry zero");

    // R7: failing condition loads literal
    drive(3'd4, 1'b1, 64'd5, 64'd5, 5'd0, 1'b0, 4'b1011, 4'd0, 4'b0000, "R7 cmp literal");
    drive(3'd5, 1'b0, 64'd5, 64'd5, 5'd0, 1'b0, 4'b0110, 4'd1, 4'b0100, "R7 cmn literal");

    // R8: immediate operand, B ignored; select ignores useImm
    drive(3'd4, 1'b1, 64'd31, 64'hDEAD, 5'd31, 1'b1, 4'd0, 4'd14, 4'd0, "R8 imm equal");
    drive(3'd4, 1'b1, 64'd0, 64'd0, 5'd1, 1'b1, 4'd0, 4'd14, 4'd0, "R8 imm borrow");
    drive(3'd0, 1'b1, 64'd7, 64'hBEEF, 5'd3, 1'b1, 4'd0, 4'd1, 4'b0100, "R8 select ignores imm");

    // R9: narrow mode
    drive(3'd0, 1'b0, 64'hFFFF_FFFF_1234_5678, 64'd0, 5'd0, 1'b0, 4'd0, 4'd14, 4'd0, "R9 upper cleared");
    drive(3'd4, 1'b0, 64'h1234_5678_8000_0000, 64'd1, 5'd0, 1'b0, 4'd0, 4'd14, 4'd0, "R9 narrow overflow");
    drive(3'd5, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 5'd0, 1'b0, 4'd0, 4'd14, 4'd0, "R9 narrow carry");
    drive(3'd3, 1'b0, 64'd0, 64'd1, 5'd0, 1'b0, 4'd0, 4'd0, 4'd0, "R9 narrow neg");

    // R10: selects keep flags
    drive(3'd2, 1'b1, 64'd1, 64'd2, 5'd0, 1'b0, 4'b0101, 4'd6, 4'b1010, "R10 inv keeps flags");
    drive(3'd1, 1'b0, 64'd1, 64'd2, 5'd0, 1'b0, 4'b0101, 4'd7, 4'b1111, "R10 inc keeps flags");

    @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule